// File: doc/BRIEF.md
# Multi-Source Mailbox Bank for Power-Management Messaging

This block is a bank of message mailboxes. Several requesting processors use it to hand short commands to a power-management processor. A requester first takes a free mailbox by writing its one-hot source ID into the mailbox's owner register. It reads that register back to learn whether it won. It then fills the data words, names the destinations and fires the message by writing its own ID to the send register. A mailbox moves through four states: free, claimed, sent and acknowledged. The acknowledged state is reached in one of two ways. A destination can answer, or the mailbox can answer by itself when auto-answer is set. The sender polls the mode register for the acknowledged code, clears its interrupt and releases the mailbox by writing its ID to the owner register once more.

All register writes except the one to the lock register are ignored until the correct key has been written to the lock register at byte offset 0xA00. Writing any other value there locks the bank again. Each mailbox takes a 64-byte window starting at m×0x40. Every source has one interrupt line. That line is the OR, over all mailboxes, of the pending bits that the mailbox's mask does not block.

Top module: `mbx_bank`

## Requirements
- R1: After reset every mailbox is free, its mode register (offset 0x10) reads 0x10 and its owner register (offset 0x00) reads 0. The lock register at 0xA00 reads 0 and all interrupt outputs are low.
- R2: Writing 0x1ACCE551 to 0xA00 unlocks the bank, after which the lock register reads 1. Writing any other value there locks it. While the bank is locked, writes to every other address are ignored.
- R3: A write to the owner register of a free mailbox claims it when the value is a valid ID. A valid ID has exactly one bit set within the low NUM_SRC bits and no other bits set. The owner register then reads that ID and mode bits [7:4] read 0x2. The state codes are 0x1 free, 0x2 claimed, 0x4 sent and 0x8 acknowledged.
- R4: A claim on a mailbox that is not free is ignored, so the owner register still reads the first owner. A claim with a value that is not a valid ID is ignored.
- R5: Writing the owner's ID to the send register (0x1C) of a claimed mailbox fires the message. Without auto-answer, the state becomes sent and the destination bits are ORed into the pending bits. A send with any other value is ignored.
- R6: Data word d sits at 0x20+4×d, for d below DATA_WORDS. A data write takes effect only when the mailbox is claimed and the access ID input equals the owner.
- R7: In the sent state, writing a valid ID to the send register acknowledges the message if that ID is a destination and is not the owner. The state becomes acknowledged, that ID's pending bit is cleared and the owner's pending bit is set.
- R8: Mode bit 0 is auto-answer. It reads back in bit 0 and can be written only by the owner, through the access ID input, while the mailbox is claimed. With auto-answer set, a send goes straight to acknowledged and ORs both the destination bits and the owner bit into the pending bits.
- R9: A write to 0x04 ORs the low NUM_SRC data bits into the destination set. A write to 0x08 clears those bits. Offset 0x0C reads the destination set.
- R10: Interrupt output s is high one cycle after some mailbox has pending bit s set and mask bit s clear. The mask is 6 bits at offset 0x14. A mask bit that is set blocks that source.
- R11: A write to offset 0x18 clears the pending bits given by the data. Reading 0x18 returns the pending bits.
- R12: Writing the owner's ID to the owner register of a mailbox that is not free releases it. The mailbox returns to free with the owner, auto-answer, destination and pending bits all cleared. The same write from any other ID changes nothing.
- R13: Read data appears on the cycle after the read strobe. Reads of mailboxes beyond NUM_MBX, data words beyond DATA_WORDS and unused offsets return 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 12 | Byte address within the bank |
| wdata_i | input | 32 | Write data |
| acc_id_i | input | NUM_SRC | One-hot ID of the requester making this access (used for data and mode writes) |
| rdata_o | output | 32 | Read data, valid one cycle after rd_en_i |
| irq_o | output | NUM_SRC | Per-source masked interrupt lines |

## Verification
The bench builds the bank with five mailboxes and two data words each. The address decode therefore meets mailbox windows above the last real mailbox and data offsets beyond the last real word, and both must read 0 and ignore writes. Four sources keep the pending, mask and interrupt relations small, so every source bit can be steered on purpose. The sequence includes losing claims, wrong-ID sends and releases, manual and automatic acknowledgement, masking, and locking the bank again.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int ADDR_W = 12;

  typedef enum logic [3:0] {
    ST_FREE    = 4'h1,
    ST_CLAIMED = 4'h2,
    ST_SENT    = 4'h4,
    ST_ACKED   = 4'h8
  } mbx_state_e;

  localparam logic [5:0] OFF_OWNER    = 6'h00;
  localparam logic [5:0] OFF_DST_SET  = 6'h04;
  localparam logic [5:0] OFF_DST_CLR  = 6'h08;
  localparam logic [5:0] OFF_DST_STAT = 6'h0C;
  localparam logic [5:0] OFF_MODE     = 6'h10;
  localparam logic [5:0] OFF_MASK     = 6'h14;
  localparam logic [5:0] OFF_ICLR     = 6'h18;
  localparam logic [5:0] OFF_SEND     = 6'h1C;

  localparam logic [ADDR_W-1:0] LOCK_ADDR  = 12'hA00;
  localparam logic [31:0]       UNLOCK_KEY = 32'h1ACC_E551;
endpackage

// File: rtl/mbx_lock.sv
module mbx_lock
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic              unlocked_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      unlocked_o <= 1'b0;
    end else if (wr_en_i && addr_i == LOCK_ADDR) begin
      unlocked_o <= (wdata_i == UNLOCK_KEY);
    end
  end

  // R2: only the key opens the bank
  p_key_only_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == LOCK_ADDR && wdata_i != UNLOCK_KEY) |=> !unlocked_o);
endmodule

// File: rtl/mbx_slot.sv
module mbx_slot
  import mbx_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int MASK_W  = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_i,
  input  logic [5:0]         off_i,
  input  logic [31:0]        wdata_i,
  input  logic [NUM_SRC-1:0] acc_id_i,
  output mbx_state_e         state_o,
  output logic [NUM_SRC-1:0] owner_o,
  output logic               auto_o,
  output logic [NUM_SRC-1:0] dest_o,
  output logic [NUM_SRC-1:0] pend_o,
  output logic [MASK_W-1:0]  mask_o,
  output logic               data_ok_o
);
  logic [NUM_SRC-1:0] wid;
  logic [31:0]        owner_w;
  logic               valid_id;

  assign wid      = wdata_i[NUM_SRC-1:0];
  assign owner_w  = 32'(owner_o);
  assign valid_id = (wdata_i[31:NUM_SRC] == '0) && ($countones(wid) == 1);

  assign data_ok_o = (state_o == ST_CLAIMED) && (acc_id_i == owner_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_o <= ST_FREE;
      owner_o <= '0;
      auto_o  <= 1'b0;
      dest_o  <= '0;
      pend_o  <= '0;
      mask_o  <= '0;
    end else if (wr_i) begin
      case (off_i)
        OFF_OWNER: begin
          if (state_o == ST_FREE && valid_id) begin
            owner_o <= wid;
            state_o <= ST_CLAIMED;
          end else if (state_o != ST_FREE && wdata_i == owner_w) begin
            state_o <= ST_FREE;
            owner_o <= '0;
            auto_o  <= 1'b0;
            dest_o  <= '0;
            pend_o  <= '0;
          end
        end
        OFF_DST_SET: dest_o <= dest_o | wid;
        OFF_DST_CLR: dest_o <= dest_o & ~wid;
        OFF_MODE: begin
          if (state_o == ST_CLAIMED && acc_id_i == owner_o) auto_o <= wdata_i[0];
        end
        OFF_MASK: mask_o <= wdata_i[MASK_W-1:0];
        OFF_ICLR: pend_o <= pend_o & ~wid;
        OFF_SEND: begin
          if (state_o == ST_CLAIMED && wdata_i == owner_w) begin
            if (auto_o) begin
              state_o <= ST_ACKED;
              pend_o  <= pend_o | dest_o | owner_o;
            end else begin
              state_o <= ST_SENT;
              pend_o  <= pend_o | dest_o;
            end
          end else if (state_o == ST_SENT && valid_id && (wid & dest_o) != '0 &&
                       wid != owner_o) begin
            state_o <= ST_ACKED;
            pend_o  <= (pend_o & ~wid) | owner_o;
          end
        end
        default: ;
      endcase
    end
  end

  // R3: state is always one of the four one-hot codes
  p_state_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot(state_o));

  // R4: an owned mailbox keeps its owner until released
  p_claim_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (state_o != ST_FREE) |=> (owner_o == $past(owner_o) || owner_o == '0));

  // R8: with auto-answer, a valid send lands directly in acknowledged
  p_auto_ack_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_i && off_i == OFF_SEND && state_o == ST_CLAIMED && wdata_i == owner_w && auto_o)
    |=> state_o == ST_ACKED);

  // R12: a free mailbox holds no owner, no auto-answer and no pending bits
  p_free_clean_r12: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_FREE) |-> (owner_o == '0 && !auto_o && pend_o == '0));
endmodule

// File: rtl/mbx_data_ram.sv
module mbx_data_ram #(
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o
);
  logic [31:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we_i) mem[addr_i] <= wdata_i;
    if (re_i) rdata_o <= mem[addr_i];
  end
endmodule

// File: rtl/mbx_irq_merge.sv
module mbx_irq_merge #(
  parameter int NUM_MBX = 8,
  parameter int NUM_SRC = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_MBX*NUM_SRC-1:0] pend_flat_i,
  input  logic [NUM_MBX*NUM_SRC-1:0] mask_flat_i,
  output logic [NUM_SRC-1:0]         irq_o
);
  logic [NUM_SRC-1:0] raw;

  always_comb begin
    raw = '0;
    for (int m = 0; m < NUM_MBX; m++) begin
      raw = raw | (pend_flat_i[m*NUM_SRC +: NUM_SRC] & ~mask_flat_i[m*NUM_SRC +: NUM_SRC]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= '0;
    else     irq_o <= raw;
  end

  // R10: no unmasked pending bit anywhere means quiet lines next cycle
  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    ((pend_flat_i & ~mask_flat_i) == '0) |=> (irq_o == '0));
endmodule

// File: rtl/mbx_bank.sv
module mbx_bank
  import mbx_pkg::*;
#(
  parameter int NUM_MBX    = 8,
  parameter int NUM_SRC    = 4,
  parameter int MASK_W     = 6,
  parameter int DATA_WORDS = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  input  logic [NUM_SRC-1:0] acc_id_i,
  output logic [31:0]        rdata_o,
  output logic [NUM_SRC-1:0] irq_o
);
  localparam int IDX_W     = ADDR_W - 6;
  localparam int RAM_DEPTH = NUM_MBX * DATA_WORDS;
  localparam int RAM_AW    = (RAM_DEPTH > 1) ? $clog2(RAM_DEPTH) : 1;

  logic [IDX_W-1:0]  idx;
  logic [5:0]        off;
  logic [2:0]        word;
  logic              idx_ok, is_data, unlocked, wr_ok;
  logic [NUM_MBX-1:0] hit_vec, data_ok_vec;

  assign idx     = addr_i[ADDR_W-1:6];
  assign off     = addr_i[5:0];
  assign word    = off[4:2];
  assign idx_ok  = 32'(idx) < NUM_MBX;
  assign is_data = off[5] && (32'(word) < DATA_WORDS);
  assign wr_ok   = wr_en_i && unlocked && idx_ok;

  mbx_lock u_lock (
    .clk        (clk),
    .rst        (rst),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .unlocked_o (unlocked)
  );

  mbx_state_e         state_a [NUM_MBX];
  logic [NUM_SRC-1:0] owner_a [NUM_MBX];
  logic [NUM_SRC-1:0] dest_a  [NUM_MBX];
  logic [NUM_SRC-1:0] pend_a  [NUM_MBX];
  logic [MASK_W-1:0]  mask_a  [NUM_MBX];
  logic               auto_a  [NUM_MBX];

  logic [NUM_MBX*NUM_SRC-1:0] pend_flat, mask_flat;
  logic [NUM_MBX*4-1:0]       state_flat;
  logic [NUM_MBX*MASK_W-1:0]  mask_all;

  for (genvar g = 0; g < NUM_MBX; g++) begin : g_slot
    assign hit_vec[g] = idx_ok && (idx == IDX_W'(g));

    mbx_slot #(.NUM_SRC(NUM_SRC), .MASK_W(MASK_W)) u_slot (
      .clk       (clk),
      .rst       (rst),
      .wr_i      (wr_ok && hit_vec[g]),
      .off_i     (off),
      .wdata_i   (wdata_i),
      .acc_id_i  (acc_id_i),
      .state_o   (state_a[g]),
      .owner_o   (owner_a[g]),
      .auto_o    (auto_a[g]),
      .dest_o    (dest_a[g]),
      .pend_o    (pend_a[g]),
      .mask_o    (mask_a[g]),
      .data_ok_o (data_ok_vec[g])
    );

    assign pend_flat[g*NUM_SRC +: NUM_SRC] = pend_a[g];
    assign mask_flat[g*NUM_SRC +: NUM_SRC] = mask_a[g][NUM_SRC-1:0];
    assign state_flat[g*4 +: 4]            = state_a[g];
    assign mask_all[g*MASK_W +: MASK_W]    = mask_a[g];
  end

  mbx_irq_merge #(.NUM_MBX(NUM_MBX), .NUM_SRC(NUM_SRC)) u_irq (
    .clk         (clk),
    .rst         (rst),
    .pend_flat_i (pend_flat),
    .mask_flat_i (mask_flat),
    .irq_o       (irq_o)
  );

  logic [RAM_AW-1:0] ram_addr;
  logic              ram_we;
  logic [31:0]       ram_q;

  assign ram_addr = RAM_AW'(32'(idx) * DATA_WORDS + 32'(word));
  assign ram_we   = wr_ok && is_data && ((data_ok_vec & hit_vec) != '0);

  mbx_data_ram #(.DEPTH(RAM_DEPTH), .AW(RAM_AW)) u_ram (
    .clk     (clk),
    .we_i    (ram_we),
    .re_i    (rd_en_i),
    .addr_i  (ram_addr),
    .wdata_i (wdata_i),
    .rdata_o (ram_q)
  );

  logic [31:0] ctl_rd, ctl_q;
  logic        sel_mem_q;

  always_comb begin
    ctl_rd = '0;
    if (addr_i == LOCK_ADDR) begin
      ctl_rd = 32'(unlocked);
    end else begin
      for (int m = 0; m < NUM_MBX; m++) begin
        if (hit_vec[m]) begin
          case (off)
            OFF_OWNER:    ctl_rd = 32'(owner_a[m]);
            OFF_DST_STAT: ctl_rd = 32'(dest_a[m]);
            OFF_MODE:     ctl_rd = {24'b0, state_a[m], 3'b0, auto_a[m]};
            OFF_MASK:     ctl_rd = 32'(mask_a[m]);
            OFF_ICLR:     ctl_rd = 32'(pend_a[m]);
            default:      ctl_rd = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q     <= '0;
      sel_mem_q <= 1'b0;
    end else if (rd_en_i) begin
      ctl_q     <= ctl_rd;
      sel_mem_q <= idx_ok && is_data;
    end
  end

  assign rdata_o = sel_mem_q ? ram_q : ctl_q;

  // R2: a locked bank leaves every mailbox state and mask untouched
  p_locked_stable_r2: assert property (@(posedge clk) disable iff (rst)
    !unlocked |=> ($stable(state_flat) && $stable(mask_all)));
endmodule

// File: tb/mbx_bank_tb_top.sv
`timescale 1ns/1ps
module mbx_bank_tb_top;
  localparam int NM = 5;
  localparam int NS = 4;
  localparam int MW = 6;
  localparam int DW = 2;
  localparam logic [31:0] KEY = 32'h1ACC_E551;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [NS-1:0] acc_id = '0;
  logic [31:0] rdata;
  logic [NS-1:0] irq;

  always #2 clk = ~clk;

  mbx_bank #(.NUM_MBX(NM), .NUM_SRC(NS), .MASK_W(MW), .DATA_WORDS(DW)) dut_i (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .acc_id_i(acc_id), .rdata_o(rdata), .irq_o(irq)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // behavioural reference state
  int m_owner [NM];
  int m_state [NM];
  int m_auto  [NM];
  int m_dest  [NM];
  int m_pend  [NM];
  int m_mask  [NM];
  logic [31:0] m_data [NM][DW];
  bit m_unl = 0;
  logic [NS-1:0] exp_irq = '0;

  initial begin
    for (int i = 0; i < NM; i++) begin
      m_owner[i] = 0; m_state[i] = 1; m_auto[i] = 0;
      m_dest[i] = 0; m_pend[i] = 0; m_mask[i] = 0;
      for (int j = 0; j < DW; j++) m_data[i][j] = '0;
    end
  end

  function automatic bit is_id(logic [31:0] v);
    return (v != 0) && (v < 16) && ($countones(v) == 1);
  endfunction

  function automatic logic [NS-1:0] model_irq();
    logic [NS-1:0] r = '0;
    for (int m = 0; m < NM; m++) r = r | NS'(m_pend[m] & ~m_mask[m]);
    return r;
  endfunction

  task automatic model_write(logic [11:0] a, logic [31:0] d, int id);
    int m, off, w, di;
    if (a == 12'hA00) begin m_unl = (d == KEY); return; end
    if (!m_unl) return;
    m = int'(a) / 64; off = int'(a) % 64;
    if (m >= NM) return;
    if (off >= 32) begin
      w = (off - 32) / 4;
      if (w < DW && m_state[m] == 2 && id == m_owner[m]) m_data[m][w] = d;
      return;
    end
    di = int'(d[NS-1:0]);
    case (off)
      0: if (m_state[m] == 1) begin
           if (is_id(d)) begin m_owner[m] = int'(d); m_state[m] = 2; end
         end else if (d == 32'(m_owner[m])) begin
           m_state[m] = 1; m_owner[m] = 0; m_auto[m] = 0; m_dest[m] = 0; m_pend[m] = 0;
         end
      4:  m_dest[m] = m_dest[m] | di;
      8:  m_dest[m] = m_dest[m] & ~di & 15;
      16: if (m_state[m] == 2 && id == m_owner[m]) m_auto[m] = int'(d[0]);
      20: m_mask[m] = int'(d[5:0]);
      24: m_pend[m] = m_pend[m] & ~di & 15;
      28: if (m_state[m] == 2 && d == 32'(m_owner[m])) begin
            m_pend[m] = m_pend[m] | m_dest[m] | (m_auto[m] != 0 ? m_owner[m] : 0);
            m_state[m] = (m_auto[m] != 0) ? 8 : 4;
          end else if (m_state[m] == 4 && is_id(d) && (di & m_dest[m]) != 0 &&
                       di != m_owner[m]) begin
            m_state[m] = 8;
            m_pend[m] = (m_pend[m] & ~di & 15) | m_owner[m];
          end
      default: ;
    endcase
  endtask

  function automatic logic [31:0] model_read(logic [11:0] a);
    int m, off, w;
    if (a == 12'hA00) return 32'(m_unl);
    m = int'(a) / 64; off = int'(a) % 64;
    if (m >= NM) return 0;
    if (off >= 32) begin
      w = (off - 32) / 4;
      return (w < DW) ? m_data[m][w] : 32'h0;
    end
    case (off)
      0:  return 32'(m_owner[m]);
      12: return 32'(m_dest[m]);
      16: return 32'((m_state[m] << 4) | m_auto[m]);
      20: return 32'(m_mask[m]);
      24: return 32'(m_pend[m]);
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) exp_irq <= model_irq();

  // R10: interrupt lines compared against the model on every clock
  always @(negedge clk) begin
    if (!rst && !done) begin
      vectors++;
      if (irq !== exp_irq) begin
        miscompares++;
        $display("FAIL R10 irq actual=%b expected=%b t=%0t", irq, exp_irq, $time);
      end
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d, logic [NS-1:0] id);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; acc_id = id;
    @(posedge clk); #1;
    wr_en = 1'b0;
    model_write(a, d, int'(id));
  endtask

  task automatic rd(logic [11:0] a, string tag);
    logic [31:0] exp;
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp = model_read(a);
    @(posedge clk); #1;
    rd_en = 1'b0;
    @(negedge clk);
    vectors++;
    if (rdata !== exp) begin
      miscompares++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rdata, exp);
    end
  endtask

  task automatic rd_lit(logic [11:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(posedge clk); #1;
    rd_en = 1'b0;
    @(negedge clk);
    vectors++;
    if (rdata !== exp) begin
      miscompares++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rdata, exp);
    end
  endtask

  task automatic chk_irq(logic [NS-1:0] exp, string tag);
    repeat (2) @(negedge clk);
    vectors++;
    if (irq !== exp) begin
      miscompares++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp);
    end
  endtask

  function automatic logic [11:0] ra(int m, int off);
    return 12'(m * 64 + off);
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    rd_lit(ra(0, 'h10), 32'h10, "R1");
    rd_lit(ra(0, 0), 32'h0, "R1");
    rd_lit(12'hA00, 32'h0, "R1");
    chk_irq(4'b0000, "R1");

    // R2 locked bank ignores writes
    wr(ra(0, 'h14), 32'h3F, 4'h1);
    wr(ra(0, 0), 32'h1, 4'h1);
    rd_lit(ra(0, 'h14), 32'h0, "R2");
    rd_lit(ra(0, 0), 32'h0, "R2");
    wr(12'hA00, KEY, 4'h1);
    rd_lit(12'hA00, 32'h1, "R2");

    // R3 claim, R4 losing claim and non-onehot claim
    wr(ra(1, 0), 32'h1, 4'h1);
    rd_lit(ra(1, 0), 32'h1, "R3");
    rd_lit(ra(1, 'h10), 32'h20, "R3");
    wr(ra(1, 0), 32'h2, 4'h2);
    rd_lit(ra(1, 0), 32'h1, "R4");
    wr(ra(3, 0), 32'h3, 4'h1);
    rd_lit(ra(3, 'h10), 32'h10, "R4");

    // R6 data words gated by owner
    wr(ra(1, 'h20), 32'hDEAD_0001, 4'h2);
    rd_lit(ra(1, 'h20), 32'h0, "R6");
    wr(ra(1, 'h20), 32'hCAFE_1234, 4'h1);
    wr(ra(1, 'h24), 32'h0000_5A5A, 4'h1);
    rd_lit(ra(1, 'h20), 32'hCAFE_1234, "R6");
    rd(ra(1, 'h24), "R6");

    // R9 destination set and clear
    wr(ra(1, 'h04), 32'hC, 4'h1);
    wr(ra(1, 'h08), 32'h4, 4'h1);
    rd_lit(ra(1, 'h0C), 32'h8, "R9");

    // R5 send: wrong ID ignored, owner ID fires
    wr(ra(1, 'h1C), 32'h2, 4'h2);
    rd_lit(ra(1, 'h10), 32'h20, "R5");
    wr(ra(1, 'h1C), 32'h1, 4'h1);
    rd_lit(ra(1, 'h10), 32'h40, "R5");
    chk_irq(4'b1000, "R5");

    // R7 manual acknowledge by a destination
    wr(ra(1, 'h1C), 32'h2, 4'h2);
    rd_lit(ra(1, 'h10), 32'h40, "R7");
    wr(ra(1, 'h1C), 32'h8, 4'h8);
    rd_lit(ra(1, 'h10), 32'h80, "R7");
    rd_lit(ra(1, 'h18), 32'h1, "R7");
    chk_irq(4'b0001, "R7");

    // R10 mask blocks the line
    wr(ra(1, 'h14), 32'h1, 4'h1);
    chk_irq(4'b0000, "R10");
    rd_lit(ra(1, 'h14), 32'h1, "R10");
    wr(ra(1, 'h14), 32'h0, 4'h1);
    chk_irq(4'b0001, "R10");

    // R11 interrupt clear
    wr(ra(1, 'h18), 32'h1, 4'h1);
    chk_irq(4'b0000, "R11");
    rd_lit(ra(1, 'h18), 32'h0, "R11");

    // R12 release: wrong ID ignored, owner releases
    wr(ra(1, 0), 32'h2, 4'h2);
    rd_lit(ra(1, 'h10), 32'h80, "R12");
    wr(ra(1, 0), 32'h1, 4'h1);
    rd_lit(ra(1, 'h10), 32'h10, "R12");
    rd_lit(ra(1, 0), 32'h0, "R12");

    // R8 auto-answer
    wr(ra(2, 0), 32'h2, 4'h2);
    wr(ra(2, 'h10), 32'h1, 4'h1);
    rd_lit(ra(2, 'h10), 32'h20, "R8");
    wr(ra(2, 'h10), 32'h1, 4'h2);
    rd_lit(ra(2, 'h10), 32'h21, "R8");
    wr(ra(2, 'h1C), 32'h2, 4'h2);
    rd_lit(ra(2, 'h10), 32'h81, "R8");
    chk_irq(4'b0010, "R8");
    wr(ra(2, 'h18), 32'h2, 4'h2);
    chk_irq(4'b0000, "R8");
    wr(ra(2, 0), 32'h2, 4'h2);
    rd_lit(ra(2, 'h10), 32'h10, "R8");

    // R13 out-of-range decode
    wr(ra(6, 0), 32'h1, 4'h1);
    rd_lit(ra(6, 0), 32'h0, "R13");
    wr(ra(4, 0), 32'h4, 4'h4);
    wr(ra(4, 'h28), 32'h1234_5678, 4'h4);
    rd_lit(ra(4, 'h28), 32'h0, "R13");
    rd_lit(ra(4, 'h1C), 32'h0, "R13");

    // R2 relock
    wr(12'hA00, 32'h0, 4'h1);
    rd_lit(12'hA00, 32'h0, "R2");
    wr(ra(3, 0), 32'h1, 4'h1);
    rd_lit(ra(3, 0), 32'h0, "R2");
    rd(ra(4, 0), "R2");

    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule